// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block runs the command protocol of a 32-bit NOR flash array made of two 16-bit devices wired side by side. A host asks for one of three jobs: program one 32-bit word, erase the block that holds an address, or probe the identifier codes. The block then issues the bus write and read cycles the job needs. Every command code goes out on both 16-bit halves in the same cycle.

For program and erase, the block polls the status register until both devices report ready. It then puts the array back in read mode and reports a result. A program also reads the word back and compares it with the data that was written. A poll limit stops a job that never becomes ready. Only one job runs at a time, and the host handshake stays closed until the result pulse.

The memory side is a simple synchronous port. A request is held, unchanged, until the memory acknowledges it.

Top module: `nor_cmd_seq`

## Requirements
- R1: `req_ready_o` is high only when the block is idle. It goes low in the cycle after a request is accepted and stays low through the cycle of `done_o`. It is high again in the next cycle.
- R2: A program job (op 0) takes these bus cycles, in order:
  - write 0x00400040 to the target word address;
  - write the data word to the same address;
  - status polling;
  - write 0x00FF00FF to the same address;
  - if no status error was seen, one read of that address.
- R3: An erase job (op 1) writes 0x00200020 and then 0x00D000D0 to the target address. It then polls status and finishes with a write of 0x00FF00FF to the same address.
- R4: Each poll is a write of 0x00700070 followed by a read of the target address. Polling continues while status bit 7 or bit 23 is clear. The device counts as ready only when both bits are set.
- R5: Every job that touches the bus, including failed and timed-out jobs, writes 0x00FF00FF as its last write before `done_o`.
- R6: An erase whose final status has bit 5 or bit 21 set ends with result 1. Otherwise it ends with result 0.
- R7: A program whose final status has bit 4 or bit 20 set ends with result 2. In that case no read-back is made after the read-mode write.
- R8: A program with clean status whose read-back word differs from the written data ends with result 3. If the read-back matches, the result is 0.
- R9: If MAX_POLLS status reads all return not-ready, the job stops polling after exactly MAX_POLLS polls and ends with result 4.
- R10: A probe job (op 2) performs these bus cycles, in order:
  - write 0x00900090 to address 0;
  - read address 0 (manufacturer code);
  - read address 1 (device code);
  - write 0x00FF00FF to address 0.

  The result is 0 only when the manufacturer code is 0x00890089 and the device code is 0x88F388F3 or 0x88F488F4. Otherwise the result is 5.
- R11: Op 3 is unsupported. It makes no bus cycle and gives `done_o` in the cycle after acceptance, with result 6.
- R12: While `mem_req_o` is high and `mem_ack_i` is low, the next cycle keeps `mem_req_o` high with the same address, direction and write data.
- R13: `done_o` is a one-cycle pulse. `err_o` is high exactly when `done_o` is high and the result is nonzero.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Job request valid |
| req_ready_o | output | 1 | Block idle and able to accept a job |
| req_op_i | input | 2 | 0 program, 1 erase, 2 probe, 3 unsupported |
| req_addr_i | input | AW | Target word address |
| req_data_i | input | 32 | Word to program |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion with a nonzero result |
| res_o | output | 3 | Result code, valid with done_o |
| mem_req_o | output | 1 | Bus cycle request |
| mem_we_o | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_addr_o | output | AW | Bus word address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_rdata_i | input | 32 | Bus read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Bus cycle acknowledge |

## Verification
The bench drives a behavioural flash model and tries the block with a range of status patterns:
- Patterns it should treat as busy: both ready bits clear, and only the low-half ready bit set. The second shows that both halves must report ready.
- Error bits raised in only one half.
- A status word that never becomes ready, which separates a timeout from a slow completion.
- A program onto bits that are already cleared, which fails the read-back but not the status check.

For probes, the bench uses the manufacturer code with each accepted device code, a wrong manufacturer code, and a non-matching device code.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROBE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RES_OK          = 3'd0,
    RES_ERASE_FAIL  = 3'd1,
    RES_PROG_FAIL   = 3'd2,
    RES_VERIFY_FAIL = 3'd3,
    RES_TIMEOUT     = 3'd4,
    RES_PROBE_FAIL  = 3'd5,
    RES_BAD_OP      = 3'd6
  } res_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ARG,
    ST_ID_DEV,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_RESTORE,
    ST_VERIFY,
    ST_DONE
  } st_e;

  // byte-wide command codes, replicated onto both 16-bit lanes
  localparam logic [15:0] C_RD_ARRAY  = 16'h00FF;
  localparam logic [15:0] C_RD_ID     = 16'h0090;
  localparam logic [15:0] C_ER_SETUP  = 16'h0020;
  localparam logic [15:0] C_ER_CONFIRM = 16'h00D0;
  localparam logic [15:0] C_PG_SETUP  = 16'h0040;
  localparam logic [15:0] C_RD_STATUS = 16'h0070;

  localparam logic [31:0] ID_MANUF   = 32'h0089_0089;
  localparam logic [31:0] ID_DEV_TOP = 32'h88F3_88F3;
  localparam logic [31:0] ID_DEV_BOT = 32'h88F4_88F4;

  localparam int unsigned SB_READY = 7;
  localparam int unsigned SB_ERASE = 5;
  localparam int unsigned SB_PROG  = 4;

  function automatic logic [31:0] dual(input logic [15:0] c);
    return {c, c};
  endfunction

endpackage

// File: rtl/nor_cmd_drive.sv
module nor_cmd_drive
  import nor_seq_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  st_e             state_i,
  input  op_e             op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     data_i,
  output logic            req_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [31:0]     wdata_o
);

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = addr_i;
    wdata_o = '0;
    unique case (state_i)
      ST_SETUP: begin
        req_o = 1'b1;
        we_o  = 1'b1;
        unique case (op_i)
          OP_PROBE: wdata_o = dual(C_RD_ID);
          OP_ERASE: wdata_o = dual(C_ER_SETUP);
          default:  wdata_o = dual(C_PG_SETUP);
        endcase
      end
      ST_ARG: begin
        req_o = 1'b1;
        if (op_i != OP_PROBE) begin
          we_o    = 1'b1;
          wdata_o = (op_i == OP_ERASE) ? dual(C_ER_CONFIRM) : data_i;
        end
      end
      ST_ID_DEV: begin
        req_o  = 1'b1;
        addr_o = addr_i + AW'(1);
      end
      ST_POLL_CMD: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = dual(C_RD_STATUS);
      end
      ST_POLL_RD: req_o = 1'b1;
      ST_RESTORE: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = dual(C_RD_ARRAY);
      end
      ST_VERIFY: req_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/nor_status_eval.sv
module nor_status_eval
  import nor_seq_pkg::*;
(
  input  op_e         op_i,
  input  logic [31:0] word_i,
  input  logic [31:0] manuf_i,
  output logic        ready_o,
  output res_e        poll_res_o,
  output res_e        probe_res_o
);

  logic erase_bad, prog_bad, dev_ok;

  // both halves must agree
  assign ready_o   = word_i[SB_READY] & word_i[SB_READY+16];
  assign erase_bad = word_i[SB_ERASE] | word_i[SB_ERASE+16];
  assign prog_bad  = word_i[SB_PROG]  | word_i[SB_PROG+16];
  assign dev_ok    = (word_i == ID_DEV_TOP) || (word_i == ID_DEV_BOT);

  always_comb begin
    if (op_i == OP_ERASE) poll_res_o = erase_bad ? RES_ERASE_FAIL : RES_OK;
    else                  poll_res_o = prog_bad  ? RES_PROG_FAIL  : RES_OK;
  end

  assign probe_res_o = (manuf_i == ID_MANUF && dev_ok) ? RES_OK : RES_PROBE_FAIL;

endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int unsigned MAX_POLLS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);

  localparam int unsigned CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end

  // current poll is the final one allowed
  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int unsigned AW        = 20,
  parameter int unsigned MAX_POLLS = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic [2:0]    res_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i
);

  st_e           state_q;
  op_e           op_q;
  res_e          res_q, pend_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q, manuf_q;

  logic ready_st, poll_last, poll_tick;
  res_e poll_res, probe_res;
  op_e  op_in;

  assign op_in = op_e'(req_op_i);

  nor_cmd_drive #(.AW(AW)) u_drive (
    .state_i (state_q),
    .op_i    (op_q),
    .addr_i  (addr_q),
    .data_i  (data_q),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  nor_status_eval u_eval (
    .op_i        (op_q),
    .word_i      (mem_rdata_i),
    .manuf_i     (manuf_q),
    .ready_o     (ready_st),
    .poll_res_o  (poll_res),
    .probe_res_o (probe_res)
  );

  assign poll_tick = (state_q == ST_POLL_RD) && mem_ack_i && !ready_st;

  nor_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .tick_i (poll_tick),
    .last_o (poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
      res_q   <= RES_OK;
      pend_q  <= RES_OK;
      addr_q  <= '0;
      data_q  <= '0;
      manuf_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q   <= op_in;
          addr_q <= (op_in == OP_PROBE) ? '0 : req_addr_i;
          data_q <= req_data_i;
          pend_q <= RES_OK;
          if (op_in == OP_RSVD) begin
            res_q   <= RES_BAD_OP;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: if (mem_ack_i) state_q <= ST_ARG;
        ST_ARG: if (mem_ack_i) begin
          if (op_q == OP_PROBE) begin
            manuf_q <= mem_rdata_i;
            state_q <= ST_ID_DEV;
          end else begin
            state_q <= ST_POLL_CMD;
          end
        end
        ST_ID_DEV: if (mem_ack_i) begin
          pend_q  <= probe_res;
          state_q <= ST_RESTORE;
        end
        ST_POLL_CMD: if (mem_ack_i) state_q <= ST_POLL_RD;
        ST_POLL_RD: if (mem_ack_i) begin
          if (ready_st) begin
            pend_q  <= poll_res;
            state_q <= ST_RESTORE;
          end else if (poll_last) begin
            pend_q  <= RES_TIMEOUT;
            state_q <= ST_RESTORE;
          end else begin
            state_q <= ST_POLL_CMD;
          end
        end
        ST_RESTORE: if (mem_ack_i) begin
          if (op_q == OP_PROG && pend_q == RES_OK) begin
            state_q <= ST_VERIFY;
          end else begin
            res_q   <= pend_q;
            state_q <= ST_DONE;
          end
        end
        ST_VERIFY: if (mem_ack_i) begin
          res_q   <= (mem_rdata_i == data_q) ? RES_OK : RES_VERIFY_FAIL;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign res_o       = res_q;
  assign err_o       = done_o && (res_q != RES_OK);

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int unsigned AW        = 20,
  parameter int unsigned MAX_POLLS = 1024
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [1:0]    req_op_i,
  input logic          done_o,
  input logic          err_o,
  input logic [2:0]    res_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i
);

  logic        accept;
  logic [31:0] poll_cnt;
  logic        saw_restore;

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_cnt    <= '0;
      saw_restore <= 1'b0;
    end else if (accept) begin
      poll_cnt    <= '0;
      saw_restore <= 1'b0;
    end else if (mem_req_o && mem_ack_i && mem_we_o) begin
      if (mem_wdata_o == 32'h0070_0070) poll_cnt <= poll_cnt + 32'd1;
      saw_restore <= (mem_wdata_o == 32'h00FF_00FF);
    end
  end

  a_r12_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  a_r1_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  a_r1_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r13_err_meaning: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && res_o != 3'd0);

  a_r11_bad_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && req_op_i == 2'd3 |=> done_o && res_o == 3'd6);

  a_r9_timeout_polls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && res_o == 3'd4 |-> poll_cnt == 32'(MAX_POLLS));

  a_r5_restore_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && res_o != 3'd6 |-> saw_restore);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .MAX_POLLS(MAX_POLLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_op_i    (req_op_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .res_o       (res_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

  localparam int AW  = 20;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_data = '0;
  logic          done, err;
  logic [2:0]    res;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          ack_r;

  nor_cmd_seq #(.AW(AW), .MAX_POLLS(MAXP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .err_o(err), .res_o(res),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(ack_r)
  );

  // flash model configuration, driven by the test process
  int          busy_polls = 0;
  logic        stuck = 1'b0;
  logic [31:0] inj = '0;
  logic [31:0] busy_word = '0;
  logic [31:0] manuf_v = 32'h0089_0089;
  logic [31:0] dev_v = 32'h88F3_88F3;
  logic        log_clr = 1'b0;

  logic [31:0] fmem [16];
  int          mode, busy_left, wn, rn, nsw, hold_viol;
  logic        pgm_pend, ers_pend, have_prev;
  logic [31:0] wa [64];
  logic [31:0] wd [64];
  logic [31:0] ra [64];
  logic [AW-1:0] p_addr;
  logic          p_we;
  logic [31:0]   p_data;

  always_comb begin
    case (mode)
      0:       mem_rdata = fmem[mem_addr[3:0]];
      1:       mem_rdata = (mem_addr[3:0] == 4'd0) ? manuf_v : dev_v;
      default: mem_rdata = (stuck || busy_left > 0) ? busy_word : (32'h0080_0080 | inj);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_r <= 1'b0; mode <= 0; busy_left <= 0; wn <= 0; rn <= 0; nsw <= 0;
      hold_viol <= 0; pgm_pend <= 1'b0; ers_pend <= 1'b0; have_prev <= 1'b0;
      for (int i = 0; i < 16; i++) fmem[i] <= 32'hFFFF_FFFF;
    end else begin
      ack_r <= mem_req && !ack_r;
      have_prev <= mem_req && !ack_r;
      p_addr <= mem_addr; p_we <= mem_we; p_data <= mem_wdata;
      if (have_prev && (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_data))
        hold_viol <= hold_viol + 1;
      if (log_clr) begin
        wn <= 0; rn <= 0; nsw <= 0;
      end else if (mem_req && ack_r) begin
        if (mem_we) begin
          if (wn < 64) begin wa[wn] <= 32'(mem_addr); wd[wn] <= mem_wdata; end
          wn <= wn + 1;
          if (pgm_pend) begin
            fmem[mem_addr[3:0]] <= fmem[mem_addr[3:0]] & mem_wdata;
            pgm_pend <= 1'b0; busy_left <= busy_polls; mode <= 2;
          end else begin
            case (mem_wdata)
              32'h00FF_00FF: mode <= 0;
              32'h0090_0090: mode <= 1;
              32'h0070_0070: begin mode <= 2; nsw <= nsw + 1; end
              32'h0040_0040: pgm_pend <= 1'b1;
              32'h0020_0020: ers_pend <= 1'b1;
              32'h00D0_00D0: if (ers_pend) begin
                for (int i = 0; i < 4; i++) fmem[{mem_addr[3:2], 2'(i)}] <= 32'hFFFF_FFFF;
                ers_pend <= 1'b0; busy_left <= busy_polls; mode <= 2;
              end
              default: ;
            endcase
          end
        end else begin
          if (rn < 64) ra[rn] <= 32'(mem_addr);
          rn <= rn + 1;
          if (mode == 2 && busy_left > 0) busy_left <= busy_left - 1;
        end
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [2:0] r, output logic e);
    int cyc = 0;
    int rdy_bad = 0;
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    while (!done && cyc < 5000) begin
      if (req_ready) rdy_bad++;
      @(negedge clk); cyc++;
    end
    if (req_ready) rdy_bad++;
    r = res; e = err;
    chk(rdy_bad == 0, "R1 ready low while busy", 32'(rdy_bad), 0);
    @(negedge clk);
    chk(!done && req_ready, "R13/R1 done single pulse, ready back", {30'd0, done, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk(req_ready && !done && !mem_req, "R1 reset state", {29'd0, req_ready, done, mem_req}, 32'd4);
  endtask

  task automatic t_prog_ok;
    logic [2:0] r; logic e;
    busy_polls = 2; inj = '0; busy_word = '0; stuck = 1'b0;
    run_op(2'd0, 20'd5, 32'h1234_5678, r, e);
    chk(r == 3'd0 && !e, "R8 program ok result", {28'd0, e, r}, 0);
    chk(wn == 6, "R2 program write count", 32'(wn), 6);
    chk(wa[0] == 5 && wd[0] == 32'h0040_0040, "R2 setup write", wd[0], 32'h0040_0040);
    chk(wa[1] == 5 && wd[1] == 32'h1234_5678, "R2 data write", wd[1], 32'h1234_5678);
    chk(nsw == 3 && wd[2] == 32'h0070_0070 && wd[4] == 32'h0070_0070, "R4 poll writes", 32'(nsw), 3);
    chk(wa[5] == 5 && wd[5] == 32'h00FF_00FF, "R5 restore after program", wd[5], 32'h00FF_00FF);
    chk(rn == 4 && ra[3] == 5, "R2 readback read", 32'(rn), 4);
    chk(fmem[5] == 32'h1234_5678, "R2 word stored", fmem[5], 32'h1234_5678);
  endtask

  task automatic t_half_ready;
    logic [2:0] r; logic e;
    busy_polls = 3; busy_word = 32'h0000_0080; inj = '0;
    run_op(2'd0, 20'd9, 32'hCAFE_F00D, r, e);
    chk(nsw == 4, "R4 one-half ready keeps polling", 32'(nsw), 4);
    chk(r == 3'd0, "R4 result after both ready", 32'(r), 0);
    busy_word = 32'h0080_0000;
    run_op(2'd1, 20'd12, '0, r, e);
    chk(nsw == 4 && r == 3'd0, "R4 upper-half ready keeps polling", 32'(nsw), 4);
    busy_word = '0;
  endtask

  task automatic t_erase_ok;
    logic [2:0] r; logic e;
    busy_polls = 1; inj = '0;
    run_op(2'd1, 20'd5, '0, r, e);
    chk(r == 3'd0 && !e, "R6 erase ok result", 32'(r), 0);
    chk(wn == 5 && wd[0] == 32'h0020_0020 && wd[1] == 32'h00D0_00D0 && wa[1] == 5,
        "R3 erase setup/confirm", wd[1], 32'h00D0_00D0);
    chk(wd[4] == 32'h00FF_00FF && wa[4] == 5, "R5 restore after erase", wd[4], 32'h00FF_00FF);
    chk(fmem[5] == 32'hFFFF_FFFF && fmem[4] == 32'hFFFF_FFFF, "R3 block erased", fmem[5], 32'hFFFF_FFFF);
  endtask

  task automatic t_erase_err;
    logic [2:0] r; logic e;
    busy_polls = 0; inj = 32'h0020_0000;
    run_op(2'd1, 20'd1, '0, r, e);
    chk(r == 3'd1 && e, "R6 erase error upper half", {28'd0, e, r}, 32'h9);
    chk(wd[wn-1] == 32'h00FF_00FF, "R5 restore after erase error", wd[wn-1], 32'h00FF_00FF);
    inj = 32'h0000_0020;
    run_op(2'd1, 20'd1, '0, r, e);
    chk(r == 3'd1, "R6 erase error lower half", 32'(r), 1);
    inj = '0;
  endtask

  task automatic t_prog_err;
    logic [2:0] r; logic e;
    busy_polls = 1; inj = 32'h0000_0010;
    run_op(2'd0, 20'd2, 32'h0F0F_0F0F, r, e);
    chk(r == 3'd2 && e, "R7 program status error", 32'(r), 2);
    chk(rn == nsw, "R7 no readback after status error", 32'(rn), 32'(nsw));
    chk(wd[wn-1] == 32'h00FF_00FF, "R5 restore after program error", wd[wn-1], 32'h00FF_00FF);
    inj = 32'h0010_0000;
    run_op(2'd0, 20'd3, 32'h0F0F_0F0F, r, e);
    chk(r == 3'd2, "R7 program error upper half", 32'(r), 2);
    inj = '0;
  endtask

  task automatic t_verify;
    logic [2:0] r; logic e;
    busy_polls = 0; inj = '0;
    run_op(2'd0, 20'd8, 32'h0000_FFFF, r, e);
    chk(r == 3'd0, "R8 first program matches", 32'(r), 0);
    run_op(2'd0, 20'd8, 32'hFFFF_0000, r, e);
    chk(r == 3'd3 && e, "R8 readback mismatch", 32'(r), 3);
  endtask

  task automatic t_timeout;
    logic [2:0] r; logic e;
    stuck = 1'b1;
    run_op(2'd1, 20'd4, '0, r, e);
    stuck = 1'b0;
    chk(r == 3'd4 && e, "R9 timeout result", 32'(r), 4);
    chk(nsw == MAXP, "R9 poll count at timeout", 32'(nsw), MAXP);
    chk(wd[wn-1] == 32'h00FF_00FF && wa[wn-1] == 4, "R5 restore after timeout", wd[wn-1], 32'h00FF_00FF);
  endtask

  task automatic t_probe;
    logic [2:0] r; logic e;
    manuf_v = 32'h0089_0089; dev_v = 32'h88F3_88F3;
    run_op(2'd2, 20'd7, '0, r, e);
    chk(r == 3'd0, "R10 probe top boot", 32'(r), 0);
    chk(wn == 2 && wa[0] == 0 && wd[0] == 32'h0090_0090, "R10 id command at 0", wd[0], 32'h0090_0090);
    chk(rn == 2 && ra[0] == 0 && ra[1] == 1, "R10 id reads at 0,1", ra[1], 1);
    chk(wa[1] == 0 && wd[1] == 32'h00FF_00FF, "R10 restore at 0", wd[1], 32'h00FF_00FF);
    dev_v = 32'h88F4_88F4;
    run_op(2'd2, 20'd0, '0, r, e);
    chk(r == 3'd0, "R10 probe bottom boot", 32'(r), 0);
    dev_v = 32'h88F1_88F1;
    run_op(2'd2, 20'd0, '0, r, e);
    chk(r == 3'd5 && e, "R10 probe wrong device", 32'(r), 5);
    dev_v = 32'h88F3_88F3; manuf_v = 32'h0089_0088;
    run_op(2'd2, 20'd0, '0, r, e);
    chk(r == 3'd5, "R10 probe wrong manufacturer", 32'(r), 5);
    manuf_v = 32'h0089_0089;
  endtask

  task automatic t_bad_op;
    logic [2:0] r; logic e;
    run_op(2'd3, 20'd5, '0, r, e);
    chk(r == 3'd6 && e, "R11 unsupported op result", 32'(r), 6);
    chk(wn == 0 && rn == 0, "R11 no bus activity", 32'(wn + rn), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_prog_ok();
    t_half_ready();
    t_erase_ok();
    t_erase_err();
    t_prog_err();
    t_verify();
    t_timeout();
    t_probe();
    t_bad_op();
    chk(hold_viol == 0, "R12 request held until ack", 32'(hold_viol), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule